// File: doc/BRIEF.md
# Five-Pin Bidirectional I/O Port

This block holds the state of a small general-purpose I/O port of five pins. Each pin has an output latch bit and a direction bit. The block drives a value and an output enable into an external tri-state pad, and it receives back the level that the pad sees. Software reaches the three registers through a simple bus with a write strobe, an address, write data and combinational read data.

The port register address and the latch register address read back different things:

- A read of the port address returns the pad levels after a two-flop synchronizer.
- A read of the latch address returns what was last written to the latch.

A write to either address updates the latch. Two external inputs can force pins to read as zero through the port address:

- An analog-select vector, one bit per pin, driven by a separate analog control register.
- A comparator-enable input, which masks the four low pins.

An open-drain line can be built without extra logic. Software clears the latch bit and then flips only the direction bit. An external pull-up supplies the high level.

Top module: `bidir_pin_port`

## Requirements
- R1: In reset, and right after it, the direction register is all ones and the latch is all zeros. As a result `padOe` = 0 and `padOut` = 0.
- R2: A direction bit of 1 clears that pin's `padOe` (input). A direction bit of 0 sets `padOe` and drives the latch bit on `padOut` (output).
- R3: A bus write to address 0 (port) or address 1 (latch) loads `wrData[4:0]` into the latch at the first rising clock edge with `wrEn` high. The direction register is not changed.
- R4: A read of address 1 returns the latch contents, not the pad levels.
- R5: A read of address 0 returns `padIn` as sampled two rising edges earlier. After a single edge the old value is still shown.
- R6: Any pin whose `anaSel` bit is 1 reads as 0 at address 0, whatever level is on its pad.
- R7: While `cmpEn` is 1, pins 3 down to 0 read as 0 at address 0. Pin 4 is unaffected.
- R8: The direction register controls `padOe` whether or not the pin is analog-selected.
- R9: With a latch bit of 0, writing only the direction bit gives a line released to its pull-up (direction 1) or driven low (direction 0). The port read follows this after two edges.
- R10: Address 2 reads and writes the direction register. Address 3 reads as 0, and writes to it change nothing.
- R11: Read data bits 7 down to 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register bus |
| addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational on `addr` |
| padIn | input | 5 | Levels seen at the pads |
| anaSel | input | 5 | Per-pin analog select from the external analog control register |
| cmpEn | input | 1 | Comparator enable; masks pins 3:0 on port reads |
| padOut | output | 5 | Value to drive on each pad |
| padOe | output | 5 | Output enable for each pad, 1 = drive |

## Verification
- Latch and direction writes appear on `padOut`, `padOe` and the readback addresses one rising edge after the strobe is presented. The bench therefore drives each strobe after a falling edge and samples after the next falling edge.
- Pad levels reach a port read only after two rising edges. The bench samples once after one edge, expecting the old value, and once after two, expecting the new one.
- The analog and comparator masks, the latch readback and the address decode are combinational on their inputs. The bench samples them a short delay after changing `addr` in the low half of the clock.

// File: rtl/bidir_pin_pkg.sv
package bidir_pin_pkg;
  localparam int ADDR_PORT = 0;
  localparam int ADDR_LAT  = 1;
  localparam int ADDR_DIR  = 2;

  typedef struct packed {
    logic latWr;
    logic dirWr;
    logic rdPort;
    logic rdLat;
    logic rdDir;
  } strobes_t;
endpackage

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import bidir_pin_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  logic hitPort, hitLat, hitDir;

  assign hitPort = (addr == ADDR_W'(ADDR_PORT));
  assign hitLat  = (addr == ADDR_W'(ADDR_LAT));
  assign hitDir  = (addr == ADDR_W'(ADDR_DIR));

  always_comb begin
    stb        = '0;
    stb.latWr  = wrEn & (hitPort | hitLat);
    stb.dirWr  = wrEn & hitDir;
    stb.rdPort = hitPort;
    stb.rdLat  = hitLat;
    stb.rdDir  = hitDir;
  end
endmodule

// File: rtl/pin_port_dp.sv
module pin_port_dp
  import bidir_pin_pkg::*;
#(
  parameter int WIDTH       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CMP_PINS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [WIDTH-1:0]  wrBits,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  anaSel,
  input  logic              cmpEn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [WIDTH-1:0] CMP_MASK = WIDTH'((1 << CMP_PINS) - 1);

  logic [WIDTH-1:0] latQ;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] digMask;
  logic [WIDTH-1:0] pinView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
      dirQ <= '1;
    end else begin
      if (stb.latWr) latQ <= wrBits;
      if (stb.dirWr) dirQ <= wrBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign digMask = ~(anaSel | (cmpEn ? CMP_MASK : '0));
  assign pinView = syncQ[SYNC_STAGES-1] & digMask;

  assign padOut = latQ;
  assign padOe  = ~dirQ;

  always_comb begin
    rdData = '0;
    unique case (1'b1)
      stb.rdPort: rdData[WIDTH-1:0] = pinView;
      stb.rdLat:  rdData[WIDTH-1:0] = latQ;
      stb.rdDir:  rdData[WIDTH-1:0] = dirQ;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/bidir_pin_port.sv
module bidir_pin_port
  import bidir_pin_pkg::*;
#(
  parameter int WIDTH    = 5,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int CMP_PINS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [WIDTH-1:0]  padIn,
  input  logic [WIDTH-1:0]  anaSel,
  input  logic              cmpEn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe
);
  strobes_t stb;

  pin_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .stb(stb)
  );

  pin_port_dp #(
    .WIDTH(WIDTH), .DATA_W(DATA_W), .SYNC_STAGES(2), .CMP_PINS(CMP_PINS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBits(wrData[WIDTH-1:0]),
    .padIn(padIn), .anaSel(anaSel), .cmpEn(cmpEn),
    .padOut(padOut), .padOe(padOe), .rdData(rdData)
  );
endmodule

// File: rtl/pin_port_chk.sv
module pin_port_chk #(
  parameter int WIDTH  = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [WIDTH-1:0]  anaSel,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe
);
  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr <= ADDR_W'(1)) |=> (padOut == $past(wrData[WIDTH-1:0])));

  p_dir_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(2)) |=> (padOe == ~$past(wrData[WIDTH-1:0])));

  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'(2)) |=> $stable(padOe));

  p_analog_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(0)) |-> ((rdData[WIDTH-1:0] & anaSel) == '0));

  p_latch_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(1)) |-> (rdData[WIDTH-1:0] == padOut));

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:WIDTH] == '0);
endmodule

bind bidir_pin_port pin_port_chk #(.WIDTH(WIDTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .anaSel(anaSel), .padOut(padOut), .padOe(padOe)
);

// File: tb/sim_bidir_pin_port.sv
`timescale 1ns/1ps
module sim_bidir_pin_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [4:0] padIn;
  logic [4:0] anaSel = 5'h1F;
  logic       cmpEn = 1'b0;
  logic [4:0] padOut;
  logic [4:0] padOe;
  logic [4:0] extLvl = 5'h1F;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < 5; i++) begin : g_pad
    assign padIn[i] = padOe[i] ? padOut[i] : extLvl[i];
  end

  bidir_pin_port u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .anaSel(anaSel), .cmpEn(cmpEn),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic settle2();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 padOe", {3'b0, padOe}, 8'h00);
    check("R1 padOut", {3'b0, padOut}, 8'h00);
    busRead(2'd2, d); check("R1 dir", d, 8'h1F);
    busRead(2'd1, d); check("R1 latch", d, 8'h00);
    busRead(2'd0, d); check("R6 analog at reset", d, 8'h00);
  endtask

  task automatic t_latchVsPort();
    logic [7:0] d;
    anaSel = 5'h00; cmpEn = 1'b0; extLvl = 5'h15;
    busWrite(2'd0, 8'hEA);
    check("R3 padOut after port write", {3'b0, padOut}, 8'h0A);
    check("R3 padOe unchanged", {3'b0, padOe}, 8'h00);
    busRead(2'd1, d); check("R4 latch readback", d, 8'h0A);
    settle2();
    busRead(2'd0, d); check("R5 port shows pads", d, 8'h15);
    busWrite(2'd1, 8'h13);
    busRead(2'd1, d); check("R3 latch write", d, 8'h13);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    @(negedge clk); extLvl = 5'h0A;
    @(negedge clk);
    busRead(2'd0, d); check("R5 one edge old", d, 8'h15);
    @(negedge clk);
    busRead(2'd0, d); check("R5 two edges new", d, 8'h0A);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    busWrite(2'd1, 8'h0A);
    busWrite(2'd2, 8'h00);
    check("R2 padOe outputs", {3'b0, padOe}, 8'h1F);
    busRead(2'd2, d); check("R10 dir readback", d, 8'h00);
    extLvl = 5'h15;
    settle2();
    busRead(2'd0, d); check("R2 driven pins read", d, 8'h0A);
    busWrite(2'd2, 8'h06);
    check("R2 mixed dir", {3'b0, padOe}, 8'h19);
  endtask

  task automatic t_analog();
    logic [7:0] d;
    busWrite(2'd2, 8'h00);
    anaSel = 5'h02;
    settle2();
    busRead(2'd0, d); check("R6 analog pin masked", d, 8'h08);
    check("R8 dir still drives", {3'b0, padOe}, 8'h1F);
    anaSel = 5'h00;
    #1; check("R6 mask released", rdData, 8'h0A);
  endtask

  task automatic t_cmp();
    logic [7:0] d;
    busWrite(2'd1, 8'h1F);
    cmpEn = 1'b1;
    settle2();
    busRead(2'd0, d); check("R7 comparator mask", d, 8'h10);
    cmpEn = 1'b0;
    #1; check("R7 comparator off", rdData, 8'h1F);
  endtask

  task automatic t_openDrain();
    logic [7:0] d;
    busWrite(2'd1, 8'h00);
    extLvl = 5'h1F;
    busWrite(2'd2, 8'h01);
    check("R9 released", {7'b0, padOe[0]}, 8'h00);
    settle2();
    busRead(2'd0, d); check("R9 pulled high", {7'b0, d[0]}, 8'h01);
    busWrite(2'd2, 8'h00);
    check("R9 driving", {6'b0, padOe[0], padOut[0]}, 8'h02);
    settle2();
    busRead(2'd0, d); check("R9 driven low", {7'b0, d[0]}, 8'h00);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    busWrite(2'd1, 8'h05);
    busWrite(2'd2, 8'h1A);
    busWrite(2'd3, 8'hFF);
    busRead(2'd3, d); check("R10 addr3 reads zero", d, 8'h00);
    busRead(2'd1, d); check("R10 latch untouched", d, 8'h05);
    busRead(2'd2, d); check("R10 dir untouched", d, 8'h1A);
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, d); check("R11 upper bits zero", d, 8'h1F);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latchVsPort();
    t_sync();
    t_dir();
    t_analog();
    t_cmp();
    t_openDrain();
    t_addr();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule